// File: doc/BRIEF.md
# Extended-Precision Classifier and Tag Encoder

This block looks at a bank of 80-bit extended-precision registers and produces two kinds of summary. For the register named by a top pointer it produces four examine-style condition bits: one sign bit plus three bits that together give the value's class. For the whole bank it converts per-register empty flags and register contents into a 2-bit-per-register full tag word and a 1-bit-per-register abridged tag byte. It also turns an incoming full tag word or abridged tag byte back into empty flags.

Each value is laid out as sign at bit 79, a 15-bit exponent at bits 78:64 and a 64-bit significand at bits 63:0. The significand's bit 63 is an explicit integer bit. Register i occupies bits i*80+79 : i*80 of the flattened register input. All results are computed combinationally. With the parameter `OUT_REG` set to 1, which is the default, they pass through one register stage.

Top module: `xp_tag_unit`

## Requirements
- R1: `cc_out` is {C3,C2,C1,C0}. C1 (`cc_out[1]`) equals the sign bit of the register selected by `top_ptr`.
- R2: An exponent of 0x7FFF with significand exactly 0x8000_0000_0000_0000 is infinity: C3=0, C2=1, C0=1.
- R3: An exponent of 0x7FFF with any other significand, zero included, is NaN: C3=0, C2=0, C0=1.
- R4: An exponent of 0 with a zero significand is zero: C3=1, C2=0, C0=0.
- R5: An exponent of 0 with a nonzero significand is denormal: C3=1, C2=1, C0=0.
- R6: Every other value is normal: C3=0, C2=1, C0=0. This holds even when the integer bit is clear.
- R7: The examine bits depend only on the contents of register `top_ptr`. Its empty flag has no effect on them.
- R8: `tag_word_out[2i+1:2i]` is 11 when register i is empty. Otherwise it is 01 for zero (exponent 0, significand 0), 10 for special (exponent 0, exponent 0x7FFF, or bit 63 clear), and 00 for all else.
- R9: `empty_word_out[i]` is 1 only when `tag_word_in[2i+1:2i]` is 11.
- R10: `tag_byte_out[i]` is the inverse of `empty_in[i]`. `empty_byte_out[i]` is the inverse of `tag_byte_in[i]`.
- R11: With `OUT_REG`=1, all outputs are zero while `rst_n` is low. Otherwise they reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| reg_vals | input | 640 | Eight 80-bit register values, register i at bits i*80+79:i*80 |
| empty_in | input | 8 | Per-register empty flags |
| top_ptr | input | 3 | Index of the register to examine |
| tag_word_in | input | 16 | Full tag word to decode |
| tag_byte_in | input | 8 | Abridged tag byte to decode |
| cc_out | output | 4 | Examine condition bits {C3,C2,C1,C0} |
| tag_word_out | output | 16 | Encoded full tag word |
| tag_byte_out | output | 8 | Encoded abridged tag byte |
| empty_word_out | output | 8 | Empty flags decoded from tag_word_in |
| empty_byte_out | output | 8 | Empty flags decoded from tag_byte_in |

## Verification
The assertions check the following on every cycle against the inputs of the previous cycle:
- the sign copy into C1;
- the infinity class code;
- the rule that C3 and C0 are never set together;
- the empty code in each tag field;
- both directions of the abridged-byte inversion;
- the full-word decode.

Only the bench's scenarios can show the remaining class cases:
- the exact infinity/NaN split at significand 0x8000_0000_0000_0000;
- an exponent of 0x7FFF with a zero significand;
- the unnormal value, which examines as normal but tags as special.

The bench scenarios also show that moving the top pointer, or marking the examined register empty, leaves the condition bits tied to that register's contents alone.

// File: rtl/xp_pkg.sv
package xp_pkg;

    typedef enum logic [2:0] {
        XC_ZERO   = 3'd0,
        XC_DENORM = 3'd1,
        XC_NORMAL = 3'd2,
        XC_INF    = 3'd3,
        XC_NAN    = 3'd4
    } xclass_e;

    typedef enum logic [1:0] {
        TG_VALID   = 2'b00,
        TG_ZERO    = 2'b01,
        TG_SPECIAL = 2'b10,
        TG_EMPTY   = 2'b11
    } tag_code_e;

endpackage

// File: rtl/xp_classify.sv
module xp_classify
    import xp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64
) (
    input  logic [EXP_W+MAN_W:0] val,
    output xclass_e              cls,
    output logic                 sign,
    output logic                 int_clr
);
    localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
    localparam logic [MAN_W-1:0] MAN_INF = {1'b1, {(MAN_W-1){1'b0}}};

    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;

    assign ex      = val[MAN_W +: EXP_W];
    assign mn      = val[MAN_W-1:0];
    assign sign    = val[EXP_W+MAN_W];
    assign int_clr = ~mn[MAN_W-1];

    always_comb begin
        if (ex == EXP_MAX) begin
            cls = (mn == MAN_INF) ? XC_INF : XC_NAN;
        end else if (ex == '0) begin
            cls = (mn == '0) ? XC_ZERO : XC_DENORM;
        end else begin
            cls = XC_NORMAL;
        end
    end
endmodule

// File: rtl/xp_tag_slot.sv
module xp_tag_slot
    import xp_pkg::*;
(
    input  xclass_e    cls,
    input  logic       int_clr,
    input  logic       empty,
    output logic [1:0] code
);
    always_comb begin
        if (empty) begin
            code = TG_EMPTY;
        end else begin
            unique case (cls)
                XC_ZERO:   code = TG_ZERO;
                XC_NORMAL: code = int_clr ? TG_SPECIAL : TG_VALID;
                default:   code = TG_SPECIAL;
            endcase
        end
    end
endmodule

// File: rtl/xp_tag_dec.sv
module xp_tag_dec #(
    parameter int NREG = 8
) (
    input  logic [2*NREG-1:0] tword,
    input  logic [NREG-1:0]   tbyte,
    output logic [NREG-1:0]   empty_w,
    output logic [NREG-1:0]   empty_b
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign empty_w[i] = (tword[2*i +: 2] == 2'b11);
        assign empty_b[i] = ~tbyte[i];
    end
endmodule

// File: rtl/xp_tag_unit.sv
module xp_tag_unit
    import xp_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int EXP_W   = 15,
    parameter int MAN_W   = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NREG*(1+EXP_W+MAN_W)-1:0] reg_vals,
    input  logic [NREG-1:0]                empty_in,
    input  logic [$clog2(NREG)-1:0]        top_ptr,
    input  logic [2*NREG-1:0]              tag_word_in,
    input  logic [NREG-1:0]                tag_byte_in,
    output logic [3:0]                     cc_out,
    output logic [2*NREG-1:0]              tag_word_out,
    output logic [NREG-1:0]                tag_byte_out,
    output logic [NREG-1:0]                empty_word_out,
    output logic [NREG-1:0]                empty_byte_out
);
    localparam int VAL_W = 1 + EXP_W + MAN_W;
    localparam int TW_W  = 2 * NREG;

    typedef struct packed {
        logic [3:0]      cc;
        logic [TW_W-1:0] tword;
        logic [NREG-1:0] tbyte;
        logic [NREG-1:0] ew;
        logic [NREG-1:0] eb;
    } out_t;

    xclass_e         cls_v [NREG];
    logic [NREG-1:0] sign_v;
    logic [NREG-1:0] intclr_v;
    logic [TW_W-1:0] tw_enc;
    logic [NREG-1:0] ew_dec;
    logic [NREG-1:0] eb_dec;
    xclass_e         sel_cls;
    out_t            out_d;
    out_t            out_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        xp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val     (reg_vals[i*VAL_W +: VAL_W]),
            .cls     (cls_v[i]),
            .sign    (sign_v[i]),
            .int_clr (intclr_v[i])
        );
        xp_tag_slot u_slot (
            .cls     (cls_v[i]),
            .int_clr (intclr_v[i]),
            .empty   (empty_in[i]),
            .code    (tw_enc[2*i +: 2])
        );
    end

    xp_tag_dec #(.NREG(NREG)) u_dec (
        .tword   (tag_word_in),
        .tbyte   (tag_byte_in),
        .empty_w (ew_dec),
        .empty_b (eb_dec)
    );

    assign sel_cls = cls_v[top_ptr];

    always_comb begin
        out_d       = '0;
        out_d.cc[1] = sign_v[top_ptr];
        unique case (sel_cls)
            XC_INF:    begin out_d.cc[2] = 1'b1; out_d.cc[0] = 1'b1; end
            XC_NAN:    out_d.cc[0] = 1'b1;
            XC_ZERO:   out_d.cc[3] = 1'b1;
            XC_DENORM: begin out_d.cc[3] = 1'b1; out_d.cc[2] = 1'b1; end
            default:   out_d.cc[2] = 1'b1;
        endcase
        out_d.tword = tw_enc;
        out_d.tbyte = ~empty_in;
        out_d.ew    = ew_dec;
        out_d.eb    = eb_dec;
    end

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_ocomb
        assign out_q = out_d;
    end

    assign cc_out         = out_q.cc;
    assign tag_word_out   = out_q.tword;
    assign tag_byte_out   = out_q.tbyte;
    assign empty_word_out = out_q.ew;
    assign empty_byte_out = out_q.eb;
endmodule

// File: rtl/xp_tag_unit_chk.sv
module xp_tag_unit_chk #(
    parameter int NREG    = 8,
    parameter int EXP_W   = 15,
    parameter int MAN_W   = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NREG*(1+EXP_W+MAN_W)-1:0] reg_vals,
    input logic [NREG-1:0]                 empty_in,
    input logic [$clog2(NREG)-1:0]         top_ptr,
    input logic [2*NREG-1:0]               tag_word_in,
    input logic [NREG-1:0]                 tag_byte_in,
    input logic [3:0]                      cc_out,
    input logic [2*NREG-1:0]               tag_word_out,
    input logic [NREG-1:0]                 tag_byte_out,
    input logic [NREG-1:0]                 empty_word_out,
    input logic [NREG-1:0]                 empty_byte_out
);
    localparam int VAL_W = 1 + EXP_W + MAN_W;

    logic [VAL_W-1:0] sel_val;
    logic             sel_is_inf;
    logic             primed_q;

    assign sel_val    = reg_vals[top_ptr*VAL_W +: VAL_W];
    assign sel_is_inf = (sel_val[MAN_W +: EXP_W] == {EXP_W{1'b1}}) &&
                        (sel_val[MAN_W-1:0] == {1'b1, {(MAN_W-1){1'b0}}});

    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R3/R4/R5: no class sets C3 and C0 together
    a_r4_c3_c0_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc_out[3] && cc_out[0]));

    if (OUT_REG) begin : g_seq
        a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
            cc_out[1] == $past(sel_val[VAL_W-1]));
        a_r2_inf: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
            $past(sel_is_inf) |-> (cc_out[2] && cc_out[0] && !cc_out[3]));
        a_r10_byte_enc: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
            tag_byte_out == ~$past(empty_in));
        a_r10_byte_dec: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
            empty_byte_out == ~$past(tag_byte_in));
        for (genvar i = 0; i < NREG; i++) begin : g_slot
            a_r8_empty_code: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                $past(empty_in[i]) |-> (tag_word_out[2*i +: 2] == 2'b11));
            a_r8_full_code: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                !$past(empty_in[i]) |-> (tag_word_out[2*i +: 2] != 2'b11));
            a_r9_word_dec: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                empty_word_out[i] == ($past(tag_word_in[2*i +: 2]) == 2'b11));
        end
    end
endmodule

bind xp_tag_unit xp_tag_unit_chk #(
    .NREG(NREG), .EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_vals(reg_vals), .empty_in(empty_in),
    .top_ptr(top_ptr), .tag_word_in(tag_word_in), .tag_byte_in(tag_byte_in),
    .cc_out(cc_out), .tag_word_out(tag_word_out), .tag_byte_out(tag_byte_out),
    .empty_word_out(empty_word_out), .empty_byte_out(empty_byte_out)
);

// File: tb/xp_tag_unit_test.sv
module xp_tag_unit_test;
    localparam int PERIOD = 10;
    localparam int N = 8;
    localparam int W = 80;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] reg_vals = '0;
    logic [N-1:0]   empty_in = '0;
    logic [2:0]     top_ptr = '0;
    logic [15:0]    tag_word_in = '0;
    logic [7:0]     tag_byte_in = '0;
    logic [3:0]     cc_out;
    logic [15:0]    tag_word_out;
    logic [7:0]     tag_byte_out;
    logic [7:0]     empty_word_out;
    logic [7:0]     empty_byte_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    xp_tag_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_vals(reg_vals), .empty_in(empty_in),
        .top_ptr(top_ptr), .tag_word_in(tag_word_in), .tag_byte_in(tag_byte_in),
        .cc_out(cc_out), .tag_word_out(tag_word_out), .tag_byte_out(tag_byte_out),
        .empty_word_out(empty_word_out), .empty_byte_out(empty_byte_out)
    );

    function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
        return {s, e, m};
    endfunction

    localparam logic [63:0] IBIT = 64'h8000_0000_0000_0000;

    function automatic logic [3:0] exp_cc(input logic [79:0] v);
        logic [3:0] c;
        c = 4'b0000;
        c[1] = v[79];
        if (v[78:64] == 15'h7fff) begin
            if (v[63:0] == IBIT) begin c[2] = 1'b1; c[0] = 1'b1; end
            else c[0] = 1'b1;
        end else if (v[78:64] == 15'h0) begin
            c[3] = 1'b1;
            if (v[63:0] != 64'h0) c[2] = 1'b1;
        end else begin
            c[2] = 1'b1;
        end
        return c;
    endfunction

    function automatic logic [1:0] exp_tag(input logic [79:0] v, input logic e);
        if (e) return 2'b11;
        if (v[78:64] == 0 && v[63:0] == 0) return 2'b01;
        if (v[78:64] == 0 || v[78:64] == 15'h7fff || !v[63]) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_reg(input int i, input logic [79:0] v);
        reg_vals[i*W +: W] = v;
    endtask

    task automatic t_reset();
        set_reg(0, mk(1'b1, 15'h7fff, IBIT));
        empty_in = 8'h5a; tag_word_in = 16'hffff; tag_byte_in = 8'h00;
        step();
        chk("R11 reset cc", {12'h0, cc_out}, 16'h0);
        chk("R11 reset tword", tag_word_out, 16'h0);
        chk("R11 reset tbyte", {8'h0, tag_byte_out}, 16'h0);
        chk("R11 reset ew/eb", {empty_word_out, empty_byte_out}, 16'h0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_examine();
        logic [79:0] vs [10];
        string nm [10];
        vs[0] = mk(0, 15'h7fff, IBIT);                 nm[0] = "R2 +inf";
        vs[1] = mk(1, 15'h7fff, IBIT);                 nm[1] = "R2 R1 -inf";
        vs[2] = mk(0, 15'h7fff, 64'hc000_0000_0000_0000); nm[2] = "R3 nan";
        vs[3] = mk(1, 15'h7fff, 64'h0);                nm[3] = "R3 nan zero significand";
        vs[4] = mk(0, 15'h7fff, IBIT | 64'h1);         nm[4] = "R3 nan near inf";
        vs[5] = mk(0, 15'h0, 64'h0);                   nm[5] = "R4 +zero";
        vs[6] = mk(1, 15'h0, 64'h0);                   nm[6] = "R4 R1 -zero";
        vs[7] = mk(0, 15'h0, 64'h1);                   nm[7] = "R5 denormal";
        vs[8] = mk(1, 15'h3fff, IBIT);                 nm[8] = "R6 R1 normal";
        vs[9] = mk(0, 15'h3fff, 64'h4000_0000_0000_0000); nm[9] = "R6 unnormal";
        empty_in = 8'h00;
        for (int k = 0; k < 10; k++) begin
            top_ptr = 3'(k % 8);
            set_reg(k % 8, vs[k]);
            step();
            chk(nm[k], {12'h0, cc_out}, {12'h0, exp_cc(vs[k])});
        end
    endtask

    task automatic t_top_select();
        for (int i = 0; i < 8; i++)
            set_reg(i, (i % 2) ? mk(1, 15'h0, 64'h0) : mk(0, 15'h7fff, IBIT));
        empty_in = 8'h00;
        for (int p = 0; p < 8; p++) begin
            top_ptr = 3'(p);
            step();
            chk("R7 top selects register", {12'h0, cc_out}, (p % 2) ? 16'h000a : 16'h0005);
        end
        top_ptr = 3'd2;
        empty_in = 8'h04;
        step();
        chk("R7 empty top ignored", {12'h0, cc_out}, 16'h0005);
        chk("R7 empty top tagged", {14'h0, tag_word_out[5:4]}, 16'h0003);
    endtask

    task automatic t_tag_word();
        logic [79:0] v [8];
        logic [15:0] ew;
        v[0] = mk(0, 15'h3fff, IBIT);
        v[1] = mk(1, 15'h0, 64'h0);
        v[2] = mk(0, 15'h0, 64'h5);
        v[3] = mk(0, 15'h7fff, IBIT);
        v[4] = mk(0, 15'h4000, 64'h1234);
        v[5] = mk(1, 15'h1, IBIT | 64'h77);
        v[6] = mk(0, 15'h7fff, 64'h0);
        v[7] = mk(0, 15'h0, 64'h0);
        for (int i = 0; i < 8; i++) set_reg(i, v[i]);
        for (int pat = 0; pat < 3; pat++) begin
            empty_in = (pat == 0) ? 8'h00 : (pat == 1) ? 8'h81 : 8'hff;
            ew = '0;
            for (int i = 0; i < 8; i++) ew[2*i +: 2] = exp_tag(v[i], empty_in[i]);
            step();
            chk("R8 full tag word", tag_word_out, ew);
            chk("R10 abridged byte", {8'h0, tag_byte_out}, {8'h0, ~empty_in});
        end
    endtask

    task automatic t_decode();
        logic [15:0] ws [4];
        logic [7:0]  bs [4];
        logic [7:0]  e;
        ws[0] = 16'hffff; ws[1] = 16'h0000; ws[2] = 16'hb6e4; ws[3] = 16'h7fbd;
        bs[0] = 8'h00; bs[1] = 8'hff; bs[2] = 8'h3c; bs[3] = 8'ha5;
        for (int k = 0; k < 4; k++) begin
            tag_word_in = ws[k];
            tag_byte_in = bs[k];
            e = '0;
            for (int i = 0; i < 8; i++) e[i] = (ws[k][2*i +: 2] == 2'b11);
            step();
            chk("R9 word decode", {8'h0, empty_word_out}, {8'h0, e});
            chk("R10 byte decode", {8'h0, empty_byte_out}, {8'h0, ~bs[k]});
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_examine();
        t_top_select();
        t_tag_word();
        t_decode();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule